// File: doc/BRIEF.md
# Calendar Real-Time Clock with Alarm

This block is a register-mapped calendar clock. It counts seconds, minutes, hours, a weekday, a day of month, a month and a two-digit year. A one-second strobe, already synchronised to the bus clock, moves the calendar forward by one second. All fields that must change on that strobe change in the same clock cycle, and the correct month length and leap-year rule apply.

A second bank of registers holds an alarm time. An alarm control byte has a master enable bit and one compare-enable bit per calendar field. When the calendar steps to a time that equals every enabled alarm field, a sticky pending flag is set, and the interrupt output follows that flag while the master enable is on. The clock starts frozen and write-protected. Software must first write a fixed seven-step key sequence, then load the time, then clear the freeze bit.

Top module: `cal_rtc`

## Requirements
- R1: After reset the freeze bit reads 1 and the calendar reads year 0, month 1, day 1, weekday 0, 00:00:00. The alarm control, pending flag, debounce field and `alarm_irq` read 0, and the block is locked.
- R2: The block unlocks only after seven writes, in order: 0xC6 to 0x04, 0x9A to 0x08, 0x59 to 0x0C, 0xA3 to 0x10, 0x57 to 0x14, 0x67 to 0x18, 0xD2 to 0x1C. Any other write before completion restarts the sequence, and it counts as the first step if it is itself that step. Once unlocked, the block stays unlocked until reset.
- R3: While locked, writes to the time, alarm, freeze, alarm-control and debounce registers are ignored.
- R4: Time field i is at 0x40+4*i and its alarm copy is at 0x60+4*i, with i = 0 year, 1 month, 2 day of month, 3 weekday, 4 hour, 5 minute, 6 second. Both are readable. A write keeps only the field width: year 7 bits, month 4, day 5, weekday 3, hour 5, minute 6, second 6.
- R5: Bit 0 at 0x20 is the freeze bit. While it is 1, strobes do not change the calendar.
- R6: A strobe increments seconds. Seconds wrap 59 to 0, minutes wrap 59 to 0 and hours wrap 23 to 0. Each wrap carries into the next field in the same cycle, and the weekday wraps 6 to 0 on the day carry.
- R7: Month and day of month are 1-based. April, June, September and November have 30 days, and the other months except February have 31. The day after the last day is day 1 of the next month, and month 12 wraps to 1 with a year carry.
- R8: February has 29 days when the year is a non-zero multiple of 4, and 28 days otherwise, including year 0.
- R9: The year wraps from 99 to 0.
- R10: At 0x7C, bit 0 is the alarm master enable and bit 7-i enables the compare of field i. An advancing strobe that makes every enabled field equal its alarm copy sets the pending flag (0x30 bit 4), in the same cycle as the time update.
- R11: `alarm_irq` is high exactly while the pending flag and the master enable are both 1. Writing 0 to 0x7C drops the interrupt but leaves the flag set.
- R12: Writing 1 to bit 4 at 0x30 clears the pending flag, and writing 0 has no effect. A set and a clear in the same cycle leave the flag set.
- R13: The debounce field at 0x2C bits 2:0 is readable and writable, and its upper bits read 0.
- R14: A write to a time field in the same cycle as a strobe loads that field, and the calendar does not advance in that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus and counter clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tick_1hz | input | 1 | One-cycle pulse per elapsed second |
| bus_we | input | 1 | Register write strobe |
| bus_addr | input | 8 | Register byte address |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Read data for `bus_addr`, combinational |
| alarm_irq | output | 1 | Alarm interrupt, active high |

## Verification
Rollover is driven with sweeps. Every second value is tried, and every hour value is tried at 59:59. Every weekday is tried at the end of a day. Every month's last day is tried in years 0, 1, 2, 4, 96 and 99, and each sweep separates a correct carry from an early or missing one and a wrong month length or leap rule. Key sequences are sent whole, broken in the middle, and restarted by a repeated first step, which tells a true ordered match from a counter that only counts writes. Alarm patterns include a full match, a one-field mismatch, a seconds-only compare, and master enable off. These show whether the per-field enable bits and the master bit are decoded as specified, and collisions of a strobe with a load or with a clear check the priorities.

// File: rtl/cal_rtc_pkg.sv
// Shared types and constants for the calendar clock.
// Assumes each calendar field fits in eight bits.
package cal_rtc_pkg;
    localparam int NFIELD = 7;
    localparam int FW     = 8;
    localparam int NKEY   = 7;

    localparam int F_YEAR = 0;
    localparam int F_MON  = 1;
    localparam int F_DOM  = 2;
    localparam int F_DOW  = 3;
    localparam int F_HOUR = 4;
    localparam int F_MIN  = 5;
    localparam int F_SEC  = 6;

    typedef logic [NFIELD-1:0][FW-1:0] cal_vec_t;

    // Address of key step s: 0x04 upward in steps of four.
    function automatic logic [7:0] key_addr(input logic [2:0] s);
        return 8'h04 + {3'b000, s, 2'b00};
    endfunction

    // Value expected at key step s.
    function automatic logic [7:0] key_val(input logic [2:0] s);
        case (s)
            3'd0:    return 8'hC6;
            3'd1:    return 8'h9A;
            3'd2:    return 8'h59;
            3'd3:    return 8'hA3;
            3'd4:    return 8'h57;
            3'd5:    return 8'h67;
            default: return 8'hD2;
        endcase
    endfunction

    // Bits kept when a field is written.
    function automatic logic [7:0] fld_mask(input logic [2:0] i);
        case (i)
            3'd0:    return 8'h7F;
            3'd1:    return 8'h0F;
            3'd2:    return 8'h1F;
            3'd3:    return 8'h07;
            3'd4:    return 8'h1F;
            default: return 8'h3F;
        endcase
    endfunction

    // Days in a month; year 0 is not a leap year.
    function automatic logic [7:0] month_days(input logic [7:0] mon, input logic [7:0] yr);
        case (mon)
            8'd2:                      return ((yr[1:0] == 2'b00) && (yr != 8'd0)) ? 8'd29 : 8'd28;
            8'd4, 8'd6, 8'd9, 8'd11:   return 8'd30;
            default:                   return 8'd31;
        endcase
    endfunction
endpackage

// File: rtl/cal_rtc_unlock.sv
// Tracks the seven-step key sequence that opens register writes.
// Assumes one bus write per cycle; the open state lasts until reset.
module cal_rtc_unlock
    import cal_rtc_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr,
    input  logic [7:0]        addr,
    input  logic [DATA_W-1:0] wdata,
    output logic              unlocked
);
    localparam logic [2:0] DONE = 3'(NKEY);

    logic [2:0] step_q;
    logic       hit_cur;
    logic       hit_first;

    // Compare the write against the expected step and against the first step.
    always_comb begin
        hit_cur   = (addr == key_addr(step_q)) && (wdata == DATA_W'(key_val(step_q)));
        hit_first = (addr == key_addr(3'd0))   && (wdata == DATA_W'(key_val(3'd0)));
    end

    // Advance, restart or hold the step counter.
    always_ff @(posedge clk) begin
        if (!rst_n)
            step_q <= 3'd0;
        else if (wr && (step_q != DONE)) begin
            if (hit_cur)        step_q <= step_q + 3'd1;
            else if (hit_first) step_q <= 3'd1;
            else                step_q <= 3'd0;
        end
    end

    assign unlocked = (step_q == DONE);
endmodule

// File: rtl/cal_rtc_counter.sv
// Calendar counter: loads single fields from the bus and advances on a strobe.
// Assumes the strobe is one cycle wide; a load suppresses that cycle's advance.
module cal_rtc_counter
    import cal_rtc_pkg::*;
#(
    parameter int YEAR_LAST = 99
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       tick,
    input  logic       stop,
    input  logic       ld_en,
    input  logic [2:0] ld_idx,
    input  logic [7:0] ld_val,
    output cal_vec_t   cur,
    output cal_vec_t   nxt,
    output logic       adv
);
    localparam logic [7:0] YL = 8'(YEAR_LAST);

    logic sec_w, min_w, hr_w, dom_w, mon_w;

    // Whether the calendar moves this cycle.
    assign adv = tick & ~stop & ~ld_en;

    // Next calendar value with carries rippling from seconds to year.
    always_comb begin
        sec_w = cur[F_SEC]  >= 8'd59;
        min_w = cur[F_MIN]  >= 8'd59;
        hr_w  = cur[F_HOUR] >= 8'd23;
        dom_w = cur[F_DOM]  >= month_days(cur[F_MON], cur[F_YEAR]);
        mon_w = cur[F_MON]  >= 8'd12;
        nxt   = cur;
        nxt[F_SEC] = sec_w ? 8'd0 : cur[F_SEC] + 8'd1;
        if (sec_w)
            nxt[F_MIN] = min_w ? 8'd0 : cur[F_MIN] + 8'd1;
        if (sec_w && min_w)
            nxt[F_HOUR] = hr_w ? 8'd0 : cur[F_HOUR] + 8'd1;
        if (sec_w && min_w && hr_w) begin
            nxt[F_DOW] = (cur[F_DOW] >= 8'd6) ? 8'd0 : cur[F_DOW] + 8'd1;
            nxt[F_DOM] = dom_w ? 8'd1 : cur[F_DOM] + 8'd1;
        end
        if (sec_w && min_w && hr_w && dom_w)
            nxt[F_MON] = mon_w ? 8'd1 : cur[F_MON] + 8'd1;
        if (sec_w && min_w && hr_w && dom_w && mon_w)
            nxt[F_YEAR] = (cur[F_YEAR] >= YL) ? 8'd0 : cur[F_YEAR] + 8'd1;
    end

    // Calendar state register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cur        <= '0;
            cur[F_MON] <= 8'd1;
            cur[F_DOM] <= 8'd1;
        end else if (ld_en)
            cur[ld_idx] <= ld_val & fld_mask(ld_idx);
        else if (adv)
            cur <= nxt;
    end
endmodule

// File: rtl/cal_rtc_alarm.sv
// Alarm bank: per-field compare against the next calendar value, sticky flag, interrupt.
// Assumes the compare uses the value the calendar takes on the advancing edge.
module cal_rtc_alarm
    import cal_rtc_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       fld_we,
    input  logic [2:0] fld_idx,
    input  logic       ctl_we,
    input  logic [7:0] wval,
    input  logic       clr,
    input  logic       adv,
    input  cal_vec_t   nxt,
    output cal_vec_t   alm,
    output logic [7:0] ctl,
    output logic       pend,
    output logic       irq
);
    logic [NFIELD-1:0] match;
    logic              fire;

    // One compare per field; a disabled field always matches.
    for (genvar i = 0; i < NFIELD; i++) begin : g_cmp
        assign match[i] = ~ctl[7-i] | (nxt[i] == alm[i]);
    end

    assign fire = adv & ctl[0] & (&match);
    assign irq  = pend & ctl[0];

    // Alarm fields, control byte and pending flag; a set beats a clear.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            alm  <= '0;
            ctl  <= 8'h00;
            pend <= 1'b0;
        end else begin
            if (fld_we) alm[fld_idx] <= wval & fld_mask(fld_idx);
            if (ctl_we) ctl <= wval;
            if (fire)     pend <= 1'b1;
            else if (clr) pend <= 1'b0;
        end
    end
endmodule

// File: rtl/cal_rtc.sv
// Top of the calendar clock: register decode, read mux, freeze and debounce bits.
// Assumes a single-cycle write port and a combinational read port.
module cal_rtc
    import cal_rtc_pkg::*;
#(
    parameter int DATA_W    = 32,
    parameter int YEAR_LAST = 99
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick_1hz,
    input  logic              bus_we,
    input  logic [7:0]        bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              alarm_irq
);
    localparam logic [7:0] A_CTRL = 8'h20;
    localparam logic [7:0] A_DEB  = 8'h2C;
    localparam logic [7:0] A_INT  = 8'h30;
    localparam logic [7:0] A_ACTL = 8'h7C;
    localparam int         PEND_B = 4;
    localparam int         DEB_W  = 3;

    logic             unlocked, wr_ok, stop_q, adv, alm_pend;
    logic             t_sel, a_sel, t_hit, a_hit;
    logic [DEB_W-1:0] deb_q;
    logic [7:0]       alm_ctl;
    cal_vec_t         cur_time, nxt_time, alm_time;

    cal_rtc_unlock #(.DATA_W(DATA_W)) u_unlock (
        .clk(clk), .rst_n(rst_n), .wr(bus_we), .addr(bus_addr),
        .wdata(bus_wdata), .unlocked(unlocked)
    );

    // Field window decode for the time and alarm banks.
    always_comb begin
        wr_ok = bus_we & unlocked;
        t_hit = (bus_addr[7:5] == 3'b010) && (bus_addr[4:2] != 3'd7) && (bus_addr[1:0] == 2'b00);
        a_hit = (bus_addr[7:5] == 3'b011) && (bus_addr[4:2] != 3'd7) && (bus_addr[1:0] == 2'b00);
        t_sel = wr_ok & t_hit;
        a_sel = wr_ok & a_hit;
    end

    cal_rtc_counter #(.YEAR_LAST(YEAR_LAST)) u_cnt (
        .clk(clk), .rst_n(rst_n), .tick(tick_1hz), .stop(stop_q),
        .ld_en(t_sel), .ld_idx(bus_addr[4:2]), .ld_val(bus_wdata[7:0]),
        .cur(cur_time), .nxt(nxt_time), .adv(adv)
    );

    cal_rtc_alarm u_alm (
        .clk(clk), .rst_n(rst_n), .fld_we(a_sel), .fld_idx(bus_addr[4:2]),
        .ctl_we(wr_ok && (bus_addr == A_ACTL)), .wval(bus_wdata[7:0]),
        .clr(bus_we && (bus_addr == A_INT) && bus_wdata[PEND_B]),
        .adv(adv), .nxt(nxt_time), .alm(alm_time), .ctl(alm_ctl),
        .pend(alm_pend), .irq(alarm_irq)
    );

    // Freeze bit and debounce field, both write-protected.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stop_q <= 1'b1;
            deb_q  <= '0;
        end else begin
            if (wr_ok && (bus_addr == A_CTRL)) stop_q <= bus_wdata[0];
            if (wr_ok && (bus_addr == A_DEB))  deb_q  <= bus_wdata[DEB_W-1:0];
        end
    end

    // Read mux; unmapped addresses read zero.
    always_comb begin
        bus_rdata = '0;
        if (t_hit)                     bus_rdata[7:0]       = cur_time[bus_addr[4:2]];
        else if (a_hit)                bus_rdata[7:0]       = alm_time[bus_addr[4:2]];
        else if (bus_addr == A_CTRL)   bus_rdata[0]         = stop_q;
        else if (bus_addr == A_DEB)    bus_rdata[DEB_W-1:0] = deb_q;
        else if (bus_addr == A_INT)    bus_rdata[PEND_B]    = alm_pend;
        else if (bus_addr == A_ACTL)   bus_rdata[7:0]       = alm_ctl;
    end
endmodule

// File: rtl/cal_rtc_chk.sv
// Temporal checks on the calendar clock, attached to the top by bind.
// Assumes the top's internal unlock, freeze, advance and pending signals.
module cal_rtc_chk
    import cal_rtc_pkg::*;
(
    input logic       clk,
    input logic       rst_n,
    input logic       bus_we,
    input logic [7:0] bus_addr,
    input logic       wd0,
    input logic       wd4,
    input logic       unlocked,
    input logic       stop,
    input logic       adv,
    input cal_vec_t   time_vec,
    input logic       pending,
    input logic       irq
);
    // R2
    sticky_unlock_chk: assert property (@(posedge clk) disable iff (!rst_n)
        unlocked |=> unlocked);

    // R3
    locked_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !unlocked |-> stop);

    // R5
    frozen_time_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (stop && !bus_we) |=> $stable(time_vec));

    // R6
    sec_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        adv |=> (time_vec[F_SEC] <= 8'd59));

    // R10
    alarm_origin_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(pending) |-> $past(adv));

    // R11
    irq_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_we && unlocked && (bus_addr == 8'h7C) && !wd0) |=> !irq);

    // R12
    w1c_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_we && (bus_addr == 8'h30) && wd4 && !adv) |=> !pending);
endmodule

bind cal_rtc cal_rtc_chk u_chk (
    .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_addr(bus_addr),
    .wd0(bus_wdata[0]), .wd4(bus_wdata[4]), .unlocked(unlocked),
    .stop(stop_q), .adv(adv), .time_vec(cur_time), .pending(alm_pend),
    .irq(alarm_irq)
);

// File: tb/tb_cal_rtc.sv
module tb_cal_rtc;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        tick_1hz = 1'b0;
    logic        bus_we = 1'b0;
    logic [7:0]  bus_addr = 8'h00;
    logic [31:0] bus_wdata = 32'h0;
    logic [31:0] bus_rdata;
    logic        alarm_irq;
    int          checks = 0;
    int          fails = 0;
    logic [31:0] d;

    cal_rtc dut (
        .clk(clk), .rst_n(rst_n), .tick_1hz(tick_1hz), .bus_we(bus_we),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .alarm_irq(alarm_irq)
    );

    always #4 clk = ~clk;

    function automatic logic [7:0] ta(input int i);
        return 8'(64 + 4 * i);
    endfunction

    function automatic logic [7:0] aa(input int i);
        return 8'(96 + 4 * i);
    endfunction

    function automatic logic [31:0] kv(input int s);
        case (s)
            0: return 32'hC6; 1: return 32'h9A; 2: return 32'h59; 3: return 32'hA3;
            4: return 32'h57; 5: return 32'h67; default: return 32'hD2;
        endcase
    endfunction

    function automatic int dim(input int m, input int y);
        if (m == 2) return ((y % 4 == 0) && (y != 0)) ? 29 : 28;
        if (m == 4 || m == 6 || m == 9 || m == 11) return 30;
        return 31;
    endfunction

    task automatic chk(input string req, input int got, input int exp);
        checks++;
        if (got != exp) begin
            fails++;
            $display("FAIL %s: got %0d expected %0d", req, got, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] v);
        @(negedge clk); bus_we = 1'b1; bus_addr = a; bus_wdata = v;
        @(negedge clk); bus_we = 1'b0;
    endtask

    task automatic wr_tick(input logic [7:0] a, input logic [31:0] v);
        @(negedge clk); bus_we = 1'b1; bus_addr = a; bus_wdata = v; tick_1hz = 1'b1;
        @(negedge clk); bus_we = 1'b0; tick_1hz = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] v);
        @(negedge clk); bus_addr = a; #1; v = bus_rdata;
    endtask

    task automatic tick();
        @(negedge clk); tick_1hz = 1'b1;
        @(negedge clk); tick_1hz = 1'b0;
    endtask

    task automatic set_time(input int y, mo, dd, w, h, mi, s);
        wr(8'h20, 32'd1);
        wr(ta(0), 32'(y));  wr(ta(1), 32'(mo)); wr(ta(2), 32'(dd)); wr(ta(3), 32'(w));
        wr(ta(4), 32'(h));  wr(ta(5), 32'(mi)); wr(ta(6), 32'(s));
        wr(8'h20, 32'd0);
    endtask

    task automatic set_alarm(input int y, mo, dd, w, h, mi, s);
        wr(aa(0), 32'(y));  wr(aa(1), 32'(mo)); wr(aa(2), 32'(dd)); wr(aa(3), 32'(w));
        wr(aa(4), 32'(h));  wr(aa(5), 32'(mi)); wr(aa(6), 32'(s));
    endtask

    task automatic chk_time(input string req, input int y, mo, dd, w, h, mi, s);
        logic [31:0] v;
        rd(ta(0), v); chk({req, " year"},   int'(v), y);
        rd(ta(1), v); chk({req, " month"},  int'(v), mo);
        rd(ta(2), v); chk({req, " day"},    int'(v), dd);
        rd(ta(3), v); chk({req, " wday"},   int'(v), w);
        rd(ta(4), v); chk({req, " hour"},   int'(v), h);
        rd(ta(5), v); chk({req, " minute"}, int'(v), mi);
        rd(ta(6), v); chk({req, " second"}, int'(v), s);
    endtask

    task automatic pend_is(input string req, input int exp_pend, input int exp_irq);
        logic [31:0] v;
        rd(8'h30, v);
        chk({req, " pending"}, int'(v[4]), exp_pend);
        chk({req, " irq"}, int'(alarm_irq), exp_irq);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        $display("FAIL watchdog (all requirements): got timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        rd(8'h20, d); chk("R1 freeze", int'(d), 1);
        chk_time("R1", 0, 1, 1, 0, 0, 0, 0);
        rd(8'h7C, d); chk("R1 alarm ctl", int'(d), 0);
        rd(8'h2C, d); chk("R1 debounce", int'(d), 0);
        pend_is("R1", 0, 0);

        // R3 locked writes ignored
        wr(ta(0), 32'd5);    rd(ta(0), d);  chk("R3 year locked", int'(d), 0);
        wr(8'h20, 32'd0);    rd(8'h20, d);  chk("R3 freeze locked", int'(d), 1);
        wr(8'h7C, 32'hFF);   rd(8'h7C, d);  chk("R3 alarm ctl locked", int'(d), 0);
        wr(8'h2C, 32'd7);    rd(8'h2C, d);  chk("R3 debounce locked", int'(d), 0);
        wr(aa(6), 32'd9);    rd(aa(6), d);  chk("R3 alarm sec locked", int'(d), 0);
        tick();              rd(ta(6), d);  chk("R3 no count while locked", int'(d), 0);

        // R2 broken sequence stays locked
        for (int s = 0; s < 3; s++) wr(8'(4 + 4 * s), kv(s));
        wr(8'h10, 32'h00);
        for (int s = 3; s < 7; s++) wr(8'(4 + 4 * s), kv(s));
        wr(ta(0), 32'd5); rd(ta(0), d); chk("R2 broken sequence", int'(d), 0);

        // R2 repeated first step restarts at step two
        wr(8'h04, kv(0)); wr(8'h08, kv(1)); wr(8'h04, kv(0));
        for (int s = 1; s < 7; s++) wr(8'(4 + 4 * s), kv(s));
        wr(ta(0), 32'd5); rd(ta(0), d); chk("R2 unlocked", int'(d), 5);
        wr(8'h04, 32'h0); wr(ta(0), 32'd6); rd(ta(0), d); chk("R2 stays unlocked", int'(d), 6);

        // R4 field widths and alarm bank read-back
        wr(ta(0), 32'hFF); rd(ta(0), d); chk("R4 year width", int'(d), 127);
        wr(ta(3), 32'hFF); rd(ta(3), d); chk("R4 wday width", int'(d), 7);
        wr(aa(5), 32'hFF); rd(aa(5), d); chk("R4 alarm minute width", int'(d), 63);
        wr(aa(1), 32'd11); rd(aa(1), d); chk("R4 alarm month", int'(d), 11);

        // R13 debounce field
        wr(8'h2C, 32'hFF); rd(8'h2C, d); chk("R13 debounce", int'(d), 7);

        // R5 freeze holds the calendar
        set_time(20, 6, 15, 2, 10, 20, 30);
        wr(8'h20, 32'd1);
        tick(); tick(); tick();
        chk_time("R5 frozen", 20, 6, 15, 2, 10, 20, 30);
        wr(8'h20, 32'd0);
        tick();
        rd(ta(6), d); chk("R5 resumed", int'(d), 31);

        // R6 second sweep
        for (int s = 0; s < 60; s++) begin
            set_time(20, 6, 15, 2, 5, 10, s);
            tick();
            rd(ta(6), d); chk("R6 second", int'(d), (s + 1) % 60);
            rd(ta(5), d); chk("R6 minute carry", int'(d), (s == 59) ? 11 : 10);
        end

        // R6 hour sweep at 59:59
        for (int h = 0; h < 24; h++) begin
            set_time(20, 6, 15, 2, h, 59, 59);
            tick();
            rd(ta(4), d); chk("R6 hour", int'(d), (h + 1) % 24);
            rd(ta(2), d); chk("R6 day carry", int'(d), (h == 23) ? 16 : 15);
        end

        // R6 weekday sweep
        for (int w = 0; w < 7; w++) begin
            set_time(20, 5, 10, w, 23, 59, 59);
            tick();
            rd(ta(3), d); chk("R6 weekday", int'(d), (w + 1) % 7);
        end

        // R7 R8 R9 end of every month in several years
        foreach (d[i]) begin end
        for (int k = 0; k < 6; k++) begin
            int y;
            y = (k == 0) ? 0 : (k == 1) ? 1 : (k == 2) ? 2 : (k == 3) ? 4 : (k == 4) ? 96 : 99;
            for (int m = 1; m <= 12; m++) begin
                set_time(y, m, dim(m, y), 3, 23, 59, 59);
                tick();
                chk_time("R7 R8 R9 month end", (m == 12) ? ((y == 99) ? 0 : y + 1) : y,
                         (m == 12) ? 1 : m + 1, 1, 4, 0, 0, 0);
            end
        end

        // R8 day 28 of February
        set_time(0, 2, 28, 0, 23, 59, 59); tick();
        rd(ta(1), d); chk("R8 year 0 February", int'(d), 3);
        set_time(8, 2, 28, 0, 23, 59, 59); tick();
        rd(ta(2), d); chk("R8 leap February day 29", int'(d), 29);

        // R9 year wrap
        set_time(99, 12, 31, 6, 23, 59, 59); tick();
        rd(ta(0), d); chk("R9 year wrap", int'(d), 0);

        // R14 load beats strobe
        set_time(20, 6, 15, 2, 1, 2, 3);
        wr_tick(ta(6), 32'd30);
        rd(ta(6), d); chk("R14 loaded second", int'(d), 30);
        rd(ta(5), d); chk("R14 minute unchanged", int'(d), 2);

        // R10 R11 R12 full match
        set_time(10, 3, 5, 2, 8, 0, 58);
        set_alarm(10, 3, 5, 2, 8, 0, 59);
        wr(8'h7C, 32'hFF);
        pend_is("R10 before match", 0, 0);
        tick();
        pend_is("R10 full match", 1, 1);
        wr(8'h30, 32'h0);  pend_is("R12 write zero", 1, 1);
        wr(8'h7C, 32'h0);  pend_is("R11 disabled", 1, 0);
        wr(8'h7C, 32'hFF); pend_is("R11 re-enabled", 1, 1);
        wr(8'h30, 32'h10); pend_is("R12 cleared", 0, 0);

        // R10 one-field mismatch
        set_time(10, 3, 5, 2, 8, 0, 58);
        set_alarm(10, 3, 5, 2, 8, 7, 59);
        tick();
        pend_is("R10 minute mismatch", 0, 0);

        // R10 seconds-only compare
        wr(8'h7C, 32'h03);
        set_time(10, 3, 5, 2, 8, 0, 58);
        tick();
        pend_is("R10 seconds only", 1, 1);
        wr(8'h30, 32'h10);
        tick();
        pend_is("R10 no match next second", 0, 0);

        // R10 master enable off
        wr(8'h7C, 32'hFE);
        set_alarm(10, 3, 5, 2, 8, 0, 59);
        set_time(10, 3, 5, 2, 8, 0, 58);
        tick();
        pend_is("R10 master off", 0, 0);

        // R12 set beats clear
        wr(8'h7C, 32'h03);
        set_time(10, 3, 5, 2, 8, 0, 58);
        wr_tick(8'h30, 32'h10);
        pend_is("R12 set beats clear", 1, 1);

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule